// File: doc/BRIEF.md
# Suspendable Erase Sequencer

This block is the control engine behind a long block erase. The erase is modelled as a counted run of steps, one step per clock cycle. The number of steps is given on an input when the erase starts. An 8-bit status word reports three things: whether the engine can accept a command, whether work is paused, and which failures have been seen. Cell physics is not modelled. A verify input sampled at the end of an operation stands in for the outcome.

A long erase can be paused so that other blocks can be used. A pause request is held until the next checkpoint, which comes every `CHECK_EVERY` completed steps. Only then does the erase stop. While the erase is paused, a program of fixed length (`PROG_CYCLES` cycles) may run on a different block. That program can itself be paused and resumed. Resuming the erase picks up at the step where it stopped.

The programming supply is checked when an erase or program is accepted. If the supply is bad, nothing runs and a distinct supply error is flagged. Failure bits stay set until a clear request arrives. All request inputs are single-cycle control pulses sampled on the rising clock edge. The block has no data stream, so no valid/ready handshake applies.

Top module: `erase_seq`

## Requirements
- R1: After reset the status word is 8'h80. Bit 7 is the ready flag; bits 6, 5, 4, 3 and 2 are zero, and bits 1 and 0 always read zero.
- R2: An accepted erase of length L (with `supply_ok` high) drops bit 7 on the accepting edge and raises it again exactly L clock edges later.
- R3: If `verify_ok` is low on the edge where an erase completes, bit 5 (erase failure) is set. If it is low on the edge where a program completes, bit 4 (program failure) is set.
- R4: An erase request while `supply_ok` is low runs no steps: bit 7 stays 1, and bits 5 and 3 (supply error) are both set.
- R5: A suspend request during an erase is held. The erase pauses on the first edge at which the count of completed steps is a nonzero multiple of `CHECK_EVERY` and below L. It does not pause if the final step comes first. While paused, bit 7 = 1 and bit 6 (erase suspended) = 1, giving status 8'hC0.
- R6: A resume from the paused erase continues it: bit 7 stays low for exactly L − t more edges, where t is the number of steps done before the pause.
- R7: A program accepted while the erase is paused, on a different `block_sel`, keeps bit 7 low for `PROG_CYCLES` edges with bit 6 still 1 (status 8'h40). It then returns to the paused erase (status 8'hC0).
- R8: A suspend request during a program pauses it on that edge, unless the program completes on that edge. The paused state shows bit 2 (program suspended) = 1 and bit 7 = 1. Resume finishes the remaining program cycles, so the total busy time is still `PROG_CYCLES`.
- R9: While an erase is paused, a program to the paused block sets bit 4 and starts nothing. An erase to the paused block sets bit 5.
- R10: Bits 5, 4 and 3 stay set until `clear_req`. A clear zeroes them on the next edge and leaves bits 7, 6 and 2 unchanged.
- R11: A program request while `supply_ok` is low starts nothing and sets bits 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| erase_req | input | 1 | Start an erase of `block_sel` (or flag misuse while paused) |
| prog_req | input | 1 | Start a program of `block_sel` |
| suspend_req | input | 1 | Pause the running erase (at a checkpoint) or program |
| resume_req | input | 1 | Continue the paused operation |
| clear_req | input | 1 | Clear status bits 5, 4, 3 |
| block_sel | input | BLK_W | Target block of an erase or program request |
| erase_len | input | CNT_W | Step count of an erase, latched at start |
| supply_ok | input | 1 | Programming supply within range |
| verify_ok | input | 1 | Outcome of the operation completing this cycle |
| status | output | 8 | {ready, erase susp, erase fail, prog fail, supply err, prog susp, 0, 0} |

## Verification
A wrong step count or a lost pause request shows at the ports as a ready low time that differs from L or from the checkpoint t. The error is visible on the edge where bit 7 should rise. A resume that restarts the erase instead of continuing it gives a second busy stretch of L rather than L − t. A misrouted return from a nested program shows bit 6 dropping, or bit 7 rising too early, within `PROG_CYCLES` edges. Sticky-bit faults appear as a status byte that changes with no clear request.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_ERASE_HELD,
    ST_PROG,
    ST_PROG_HELD
  } seq_state_e;

  localparam int SR_READY      = 7;
  localparam int SR_ERASE_HELD = 6;
  localparam int SR_ERASE_FAIL = 5;
  localparam int SR_PROG_FAIL  = 4;
  localparam int SR_SUPPLY_ERR = 3;
  localparam int SR_PROG_HELD  = 2;
endpackage

// File: rtl/erase_seq_steps.sv
module erase_seq_steps #(
  parameter int CNT_W       = 12,
  parameter int CHECK_EVERY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [CNT_W-1:0] limit,
  output logic             at_end,
  output logic             at_checkpoint,
  output logic [CNT_W-1:0] count
);
  localparam int PH_W = (CHECK_EVERY > 1) ? $clog2(CHECK_EVERY) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      lim_q <= limit;
    end else if (advance) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // the step in progress is the last one when count+1 reaches the limit
  assign at_end = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, lim_q};
  assign count  = cnt_q;

  generate
    if (CHECK_EVERY > 1) begin : g_phase
      logic [PH_W-1:0] phase_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          phase_q <= '0;
        else if (load)
          phase_q <= '0;
        else if (advance)
          phase_q <= (phase_q == PH_W'(CHECK_EVERY-1)) ? '0 : phase_q + 1'b1;
      end
      assign at_checkpoint = (phase_q == PH_W'(CHECK_EVERY-1));
    end else begin : g_every
      assign at_checkpoint = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/erase_seq_ptimer.sv
module erase_seq_ptimer #(
  parameter int PROG_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic advance,
  output logic done
);
  localparam int TW   = $clog2(PROG_CYCLES + 1);
  localparam int LAST = PROG_CYCLES - 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= '0;
    else if (advance)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == TW'(LAST));
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int BLK_W       = 4,
  parameter int CNT_W       = 12,
  parameter int CHECK_EVERY = 4,
  parameter int PROG_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_req,
  input  logic             prog_req,
  input  logic             suspend_req,
  input  logic             resume_req,
  input  logic             clear_req,
  input  logic [BLK_W-1:0] block_sel,
  input  logic [CNT_W-1:0] erase_len,
  input  logic             supply_ok,
  input  logic             verify_ok,
  output logic [7:0]       status
);
  seq_state_e       state_q, state_d;
  logic             nested_q, nested_d;
  logic             pend_q, pend_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [2:0]       err_q, err_d;   // {erase fail, prog fail, supply}
  logic             set_e, set_p, set_v;
  logic             step_load, step_adv, step_end, step_chk;
  logic [CNT_W-1:0] step_count;
  logic             tmr_load, tmr_adv, tmr_done;

  erase_seq_steps #(.CNT_W(CNT_W), .CHECK_EVERY(CHECK_EVERY)) u_steps (
    .clk(clk), .rst_n(rst_n), .load(step_load), .advance(step_adv),
    .limit(erase_len), .at_end(step_end), .at_checkpoint(step_chk),
    .count(step_count)
  );

  erase_seq_ptimer #(.PROG_CYCLES(PROG_CYCLES)) u_ptimer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .advance(tmr_adv),
    .done(tmr_done)
  );

  always_comb begin
    state_d   = state_q;
    nested_d  = nested_q;
    pend_d    = pend_q;
    blk_d     = blk_q;
    set_e     = 1'b0;
    set_p     = 1'b0;
    set_v     = 1'b0;
    step_load = 1'b0;
    step_adv  = 1'b0;
    tmr_load  = 1'b0;
    tmr_adv   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (erase_req) begin
          if (!supply_ok) begin
            set_e = 1'b1;
            set_v = 1'b1;
          end else begin
            state_d   = ST_ERASE;
            step_load = 1'b1;
            pend_d    = 1'b0;
            blk_d     = block_sel;
          end
        end else if (prog_req) begin
          if (!supply_ok) begin
            set_p = 1'b1;
            set_v = 1'b1;
          end else begin
            state_d  = ST_PROG;
            tmr_load = 1'b1;
            nested_d = 1'b0;
          end
        end
      end
      ST_ERASE: begin
        step_adv = 1'b1;
        if (step_end) begin
          state_d = ST_IDLE;
          pend_d  = 1'b0;
          set_e   = !verify_ok;
        end else if ((pend_q || suspend_req) && step_chk) begin
          state_d = ST_ERASE_HELD;
          pend_d  = 1'b0;
        end else if (suspend_req) begin
          pend_d = 1'b1;
        end
      end
      ST_ERASE_HELD: begin
        if (resume_req) begin
          state_d = ST_ERASE;
        end else if (prog_req) begin
          if (block_sel == blk_q) begin
            set_p = 1'b1;
          end else if (!supply_ok) begin
            set_p = 1'b1;
            set_v = 1'b1;
          end else begin
            state_d  = ST_PROG;
            tmr_load = 1'b1;
            nested_d = 1'b1;
          end
        end else if (erase_req && (block_sel == blk_q)) begin
          set_e = 1'b1;
        end
      end
      ST_PROG: begin
        if (tmr_done) begin
          state_d  = nested_q ? ST_ERASE_HELD : ST_IDLE;
          nested_d = 1'b0;
          set_p    = !verify_ok;
        end else begin
          tmr_adv = 1'b1;
          if (suspend_req) state_d = ST_PROG_HELD;
        end
      end
      ST_PROG_HELD: begin
        if (resume_req) state_d = ST_PROG;
      end
      default: state_d = ST_IDLE;
    endcase
    err_d = (clear_req ? 3'b000 : err_q) | {set_e, set_p, set_v};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      nested_q <= 1'b0;
      pend_q   <= 1'b0;
      blk_q    <= '0;
      err_q    <= '0;
    end else begin
      state_q  <= state_d;
      nested_q <= nested_d;
      pend_q   <= pend_d;
      blk_q    <= blk_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    status                = '0;
    status[SR_READY]      = (state_q == ST_IDLE) || (state_q == ST_ERASE_HELD) ||
                            (state_q == ST_PROG_HELD);
    status[SR_ERASE_HELD] = (state_q == ST_ERASE_HELD) || nested_q;
    status[SR_ERASE_FAIL] = err_q[2];
    status[SR_PROG_FAIL]  = err_q[1];
    status[SR_SUPPLY_ERR] = err_q[0];
    status[SR_PROG_HELD]  = (state_q == ST_PROG_HELD);
  end

  // a pause is entered only with a whole number of checkpoints completed
  assert_pause_on_checkpoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE_HELD && $past(state_q) == ST_ERASE) |->
      (step_count != '0 && (int'(step_count) % CHECK_EVERY) == 0))
    else $error("pause away from checkpoint");

  // progress of a paused erase is frozen
  assert_hold_progress_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE_HELD && $past(state_q) == ST_ERASE_HELD) |-> $stable(step_count))
    else $error("paused erase progress moved");

  // bad supply at start keeps the engine idle and flags it
  assert_supply_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && erase_req && !supply_ok) |=> (state_q == ST_IDLE && status[SR_SUPPLY_ERR]))
    else $error("erase started with bad supply");

  assert_sticky_efail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[SR_ERASE_FAIL] && !clear_req) |=> status[SR_ERASE_FAIL])
    else $error("erase fail bit dropped");

  assert_sticky_pfail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[SR_PROG_FAIL] && !clear_req) |=> status[SR_PROG_FAIL])
    else $error("program fail bit dropped");

  assert_sticky_supply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[SR_SUPPLY_ERR] && !clear_req) |=> status[SR_SUPPLY_ERR])
    else $error("supply bit dropped");
endmodule

// File: tb/erase_seq_test.sv
module erase_seq_test;
  localparam int BLK_W = 4;
  localparam int CNT_W = 12;
  localparam int NCHK  = 4;
  localparam int PCYC  = 6;

  // fields: length, suspend-at cycle (0 none), expected pause t (0 none), verify
  localparam logic [31:0] VECS [8] = '{
    32'h0A_00_00_01, 32'h0A_01_04_01, 32'h0A_04_04_01, 32'h0A_05_08_01,
    32'h0A_09_00_01, 32'h08_06_00_01, 32'h03_01_00_01, 32'h0C_00_00_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic erase_req = 1'b0, prog_req = 1'b0, suspend_req = 1'b0;
  logic resume_req = 1'b0, clear_req = 1'b0;
  logic [BLK_W-1:0] block_sel = '0;
  logic [CNT_W-1:0] erase_len = '0;
  logic supply_ok = 1'b1, verify_ok = 1'b1;
  logic [7:0] status;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  erase_seq #(.BLK_W(BLK_W), .CNT_W(CNT_W), .CHECK_EVERY(NCHK), .PROG_CYCLES(PCYC)) uut (
    .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .prog_req(prog_req),
    .suspend_req(suspend_req), .resume_req(resume_req), .clear_req(clear_req),
    .block_sel(block_sel), .erase_len(erase_len), .supply_ok(supply_ok),
    .verify_ok(verify_ok), .status(status)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic start_erase(input int blk, input int len);
    erase_req = 1'b1; block_sel = BLK_W'(blk); erase_len = CNT_W'(len);
    @(negedge clk);
    erase_req = 1'b0;
  endtask

  task automatic start_prog(input int blk);
    prog_req = 1'b1; block_sel = BLK_W'(blk);
    @(negedge clk);
    prog_req = 1'b0;
  endtask

  task automatic pulse_resume();
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
  endtask

  task automatic pulse_clear();
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
  endtask

  task automatic count_busy(input int sus_at, output int busy);
    busy = 0;
    for (int k = 1; k < 2000 && !status[7]; k++) begin
      busy++;
      suspend_req = (k == sus_at);
      @(negedge clk);
    end
    suspend_req = 1'b0;
  endtask

  initial begin
    int busy;
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset release", status, 8'h80);

    // table walk: erase length, suspend point, resume continuation
    for (int i = 0; i < 8; i++) begin
      int len, sus, tp, vfy;
      len = int'(VECS[i][31:24]);
      sus = int'(VECS[i][23:16]);
      tp  = int'(VECS[i][15:8]);
      vfy = int'(VECS[i][7:0]);
      verify_ok = vfy[0];
      start_erase(1, len);
      count_busy(sus, busy);
      check("R2/R5 busy before ready", busy, (tp != 0) ? tp : len);
      if (tp != 0) begin
        check("R5 paused status", status, 8'hC0);
        pulse_resume();
        count_busy(0, busy);
        check("R6 remaining busy after resume", busy, len - tp);
      end
      check("R2/R3 final status", status, vfy[0] ? 8'h80 : 8'hA0);
      pulse_clear();
      check("R10 clear after vector", status, 8'h80);
    end
    verify_ok = 1'b1;

    // R4 bad supply blocks erase
    supply_ok = 1'b0;
    start_erase(2, 10);
    supply_ok = 1'b1;
    check("R4 ready stays high, bits 5,3", status, 8'hA8);
    repeat (5) @(negedge clk);
    check("R10 error bits sticky", status, 8'hA8);
    pulse_clear();
    check("R10 clear zeroes error bits", status, 8'h80);

    // nested program inside an erase pause
    start_erase(3, 20);
    count_busy(1, busy);
    check("R5 pause at first checkpoint", busy, 4);
    check("R5 paused status", status, 8'hC0);
    start_prog(3);
    check("R9 program to paused block rejected", status, 8'hD0);
    pulse_clear();
    check("R10 clear keeps bit 6", status, 8'hC0);
    start_erase(3, 20);
    check("R9 erase to paused block rejected", status, 8'hE0);
    pulse_clear();
    supply_ok = 1'b0;
    start_prog(5);
    supply_ok = 1'b1;
    check("R11 nested program with bad supply", status, 8'hD8);
    pulse_clear();
    start_prog(5);
    check("R7 nested program running", status, 8'h40);
    count_busy(2, busy);
    check("R8 program paused after 2 busy", busy, 2);
    check("R8 program paused status", status, 8'hC4);
    pulse_resume();
    count_busy(0, busy);
    check("R8 program remainder", busy, PCYC - 2);
    check("R7 back to paused erase", status, 8'hC0);
    pulse_resume();
    count_busy(0, busy);
    check("R6 erase remainder after nest", busy, 16);
    check("R6 final status", status, 8'h80);

    // standalone program with failed verify
    verify_ok = 1'b0;
    start_prog(7);
    count_busy(0, busy);
    verify_ok = 1'b1;
    check("R3 program busy length", busy, PCYC);
    check("R3 program fail bit", status, 8'h90);
    pulse_clear();

    // program with bad supply
    supply_ok = 1'b0;
    start_prog(7);
    supply_ok = 1'b1;
    check("R11 program with bad supply", status, 8'h98);
    pulse_clear();
    check("R10 clear after program errors", status, 8'h80);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule